// File: doc/BRIEF.md
# Infrared pulse-width bit decoder

This block receives the output of an infrared demodulator, which is already stripped of its carrier, and turns a burst of pulses into a data word. It measures each active pulse in units of a 0.1 ms time base and sorts the result into one of three classes: a long start marker, a medium pulse meaning logic one, or a short pulse meaning logic zero. Data bits are accepted only after a valid start marker. They are shifted into a word register, and once the configured number of bits has arrived the word is presented together with a single-cycle strobe.

The time base is a divider that produces a one-clock enable every `CLK_PER_TICK` clocks. At the default of 5000, a 50 MHz clock gives a 0.1 ms tick. The raw line passes through a multi-flop synchroniser before it is measured. A pulse whose width falls in no acceptance window raises a one-cycle error strobe and drops the partial frame. A line held active too long raises the same strobe and also drops the partial frame.

Top module: `ir_pulse_decoder`

## Requirements
- R1: A tick enable is high for exactly one clock in every `CLK_PER_TICK` clocks (default 5000, which is 0.1 ms at 50 MHz). It comes from a counter that runs from 0 to `CLK_PER_TICK-1` and is cleared by the synchronous reset.
- R2: `ir_line_i` (active high) is retimed through `SYNC_STAGES` flops (default 2). The width of a pulse is the number of ticks that occur while the retimed line is high, counted from its rising edge to its falling edge.
- R3: Widths are classed as follows. A start is 25 ticks, a one is 12 ticks and a zero is 6 ticks, and each is accepted within plus or minus `TOL_TICKS` (default 2) inclusive. With the defaults the windows are therefore 23..27, 10..14 and 4..8.
- R4: While no start has been accepted, one and zero pulses are ignored. They produce no `valid_o`, no `err_o` and no change to `word_o`.
- R5: Bits are collected least significant bit first, so the first data pulse after a start lands in `word_o[0]`.
- R6: When the `WORD_BITS`-th (default 12) data pulse is classified, `word_o` is loaded and `valid_o` is high for exactly one clock. The decoder then waits for a new start.
- R7: A completed pulse whose width lies outside every window makes `err_o` high for one clock. Any partial frame is discarded, and data pulses that follow are ignored until the next start.
- R8: If the retimed line stays high for more than `TIMEOUT_TICKS` (default 40) ticks, `err_o` is high for one clock while the line is still high. The frame is aborted, and the eventual falling edge of that pulse is not classified.
- R9: A start pulse that arrives in the middle of a frame discards the bits collected so far and begins a new frame.
- R10: After reset, `word_o` is 0 and `valid_o` and `err_o` are low. `word_o` changes only together with `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ir_line_i | input | 1 | Demodulated infrared line, active high, asynchronous |
| word_o | output | WORD_BITS | Last complete decoded word |
| valid_o | output | 1 | One-cycle strobe marking a new word |
| err_o | output | 1 | One-cycle strobe for a bad width or an over-long pulse |

## Verification
The bench drives pulses at the exact edges of each acceptance window (23, 27, 10, 14, 4 and 8 ticks) and also one tick outside them (9 and 28). A comparator that is off by one would either drop a good frame or accept a bad pulse, and both show up as a mismatch against the expected event queue. Twelve data pulses are sent before any start and again right after an error. A decoder that failed to ignore them, or that did not return to waiting for a start, would raise an unexpected `valid_o`. An over-long pulse must produce exactly one error and nothing at its falling edge, and a start in mid-frame must restart the bit count. A design that classified the late falling edge, or that kept the old bits, would emit an extra event or the wrong word.

// File: rtl/ir_dec_pkg.sv
package ir_dec_pkg;

   typedef enum logic [1:0] {
      PC_BAD   = 2'd0,
      PC_START = 2'd1,
      PC_ONE   = 2'd2,
      PC_ZERO  = 2'd3
   } pulse_class_e;

   typedef enum logic {
      ST_HUNT = 1'b0,
      ST_BITS = 1'b1
   } frame_state_e;

endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
   parameter int CLK_PER_TICK = 5000
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic tick_o
);
   localparam int DW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
   localparam logic [DW-1:0] LAST = DW'(CLK_PER_TICK - 1);

   logic [DW-1:0] div_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         div_q  <= '0;
         tick_o <= 1'b0;
      end else if (div_q == LAST) begin
         div_q  <= '0;
         tick_o <= 1'b1;
      end else begin
         div_q  <= div_q + 1'b1;
         tick_o <= 1'b0;
      end
   end
endmodule

// File: rtl/ir_line_sync.sv
module ir_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   logic [SYNC_STAGES-1:0] ff_q;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i) begin
            if (rst_i) ff_q[0] <= 1'b0;
            else       ff_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i) begin
            if (rst_i) ff_q[s] <= 1'b0;
            else       ff_q[s] <= ff_q[s-1];
         end
      end
   end

   assign q_o = ff_q[SYNC_STAGES-1];
endmodule

// File: rtl/ir_width_meter.sv
module ir_width_meter #(
   parameter int TIMEOUT_TICKS = 40,
   parameter int CW            = 6
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          tick_i,
   input  logic          line_i,
   output logic          done_o,
   output logic [CW-1:0] width_o,
   output logic          long_o
);
   localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_TICKS);

   logic          prev_q;
   logic          over_q;
   logic [CW-1:0] cnt_q;
   logic          rise, fall;

   assign rise = line_i & ~prev_q;
   assign fall = ~line_i & prev_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         prev_q  <= 1'b0;
         over_q  <= 1'b0;
         cnt_q   <= '0;
         done_o  <= 1'b0;
         width_o <= '0;
         long_o  <= 1'b0;
      end else begin
         prev_q <= line_i;
         done_o <= 1'b0;
         long_o <= 1'b0;
         if (rise) begin
            cnt_q  <= tick_i ? CW'(1) : '0;
            over_q <= 1'b0;
         end else if (line_i && tick_i && !over_q) begin
            if (cnt_q == LIMIT) begin
               over_q <= 1'b1;
               long_o <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         if (fall && !over_q) begin
            done_o  <= 1'b1;
            width_o <= cnt_q;
         end
      end
   end
endmodule

// File: rtl/ir_frame_asm.sv
module ir_frame_asm
   import ir_dec_pkg::*;
#(
   parameter int WORD_BITS   = 12,
   parameter int CW          = 6,
   parameter int START_TICKS = 25,
   parameter int ONE_TICKS   = 12,
   parameter int ZERO_TICKS  = 6,
   parameter int TOL_TICKS   = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic                 done_i,
   input  logic [CW-1:0]        width_i,
   input  logic                 long_i,
   output logic [WORD_BITS-1:0] word_o,
   output logic                 valid_o,
   output logic                 err_o
);
   localparam int BW = $clog2(WORD_BITS + 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(WORD_BITS - 1);

   frame_state_e         state_q;
   logic [BW-1:0]        bits_q;
   logic [WORD_BITS-1:0] sh_q;
   logic [WORD_BITS-1:0] sh_next;
   pulse_class_e         cls;

   function automatic logic in_win(input int w, input int centre);
      return (w >= centre - TOL_TICKS) && (w <= centre + TOL_TICKS);
   endfunction

   always_comb begin
      if (in_win(int'(width_i), START_TICKS))     cls = PC_START;
      else if (in_win(int'(width_i), ONE_TICKS))  cls = PC_ONE;
      else if (in_win(int'(width_i), ZERO_TICKS)) cls = PC_ZERO;
      else                                        cls = PC_BAD;
   end

   assign sh_next = {(cls == PC_ONE), sh_q[WORD_BITS-1:1]};

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= ST_HUNT;
         bits_q  <= '0;
         sh_q    <= '0;
         word_o  <= '0;
         valid_o <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         err_o   <= 1'b0;
         if (long_i) begin
            err_o   <= 1'b1;
            state_q <= ST_HUNT;
         end else if (done_i) begin
            unique case (cls)
               PC_BAD: begin
                  err_o   <= 1'b1;
                  state_q <= ST_HUNT;
               end
               PC_START: begin
                  state_q <= ST_BITS;
                  bits_q  <= '0;
                  sh_q    <= '0;
               end
               default: begin
                  if (state_q == ST_BITS) begin
                     if (bits_q == LAST_BIT) begin
                        word_o  <= sh_next;
                        valid_o <= 1'b1;
                        state_q <= ST_HUNT;
                     end else begin
                        sh_q   <= sh_next;
                        bits_q <= bits_q + 1'b1;
                     end
                  end
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/ir_pulse_decoder.sv
module ir_pulse_decoder #(
   parameter int CLK_PER_TICK  = 5000,
   parameter int SYNC_STAGES   = 2,
   parameter int WORD_BITS     = 12,
   parameter int START_TICKS   = 25,
   parameter int ONE_TICKS     = 12,
   parameter int ZERO_TICKS    = 6,
   parameter int TOL_TICKS     = 2,
   parameter int TIMEOUT_TICKS = 40
) (
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic                 ir_line_i,
   output logic [WORD_BITS-1:0] word_o,
   output logic                 valid_o,
   output logic                 err_o
);
   localparam int CW = $clog2(TIMEOUT_TICKS + 2);

   if (CLK_PER_TICK < 2) begin : g_bad_div
      $error("CLK_PER_TICK must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (WORD_BITS < 2) begin : g_bad_word
      $error("WORD_BITS must be at least 2");
   end
   if (ZERO_TICKS - TOL_TICKS < 1) begin : g_bad_zero
      $error("zero window must not reach width 0");
   end
   if (ZERO_TICKS + TOL_TICKS >= ONE_TICKS - TOL_TICKS ||
       ONE_TICKS + TOL_TICKS >= START_TICKS - TOL_TICKS) begin : g_bad_win
      $error("acceptance windows overlap");
   end
   if (TIMEOUT_TICKS < START_TICKS + TOL_TICKS) begin : g_bad_tmo
      $error("timeout shorter than the start window");
   end

   logic          tick;
   logic          line_s;
   logic          done;
   logic [CW-1:0] width;
   logic          too_long;

   ir_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .tick_o(tick)
   );

   ir_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i),
      .rst_i(rst_i),
      .d_i  (ir_line_i),
      .q_o  (line_s)
   );

   ir_width_meter #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .CW(CW)) u_meter (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .tick_i (tick),
      .line_i (line_s),
      .done_o (done),
      .width_o(width),
      .long_o (too_long)
   );

   ir_frame_asm #(
      .WORD_BITS  (WORD_BITS),
      .CW         (CW),
      .START_TICKS(START_TICKS),
      .ONE_TICKS  (ONE_TICKS),
      .ZERO_TICKS (ZERO_TICKS),
      .TOL_TICKS  (TOL_TICKS)
   ) u_asm (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .done_i (done),
      .width_i(width),
      .long_i (too_long),
      .word_o (word_o),
      .valid_o(valid_o),
      .err_o  (err_o)
   );
endmodule

// File: rtl/ir_pulse_decoder_chk.sv
module ir_pulse_decoder_chk #(
   parameter int CLK_PER_TICK = 5000,
   parameter int WORD_BITS    = 12
) (
   input logic                 clk_i,
   input logic                 rst_i,
   input logic                 tick,
   input logic [WORD_BITS-1:0] word_o,
   input logic                 valid_o,
   input logic                 err_o
);
   localparam int GW = $clog2(CLK_PER_TICK + 1);

   logic [GW-1:0] gap_q;
   logic          seen_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (tick) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else begin
         gap_q <= gap_q + 1'b1;
      end
   end

   AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
      (tick && seen_q) |-> (gap_q == GW'(CLK_PER_TICK - 1)));  // R1

   AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |=> !valid_o);  // R6

   AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
      err_o |=> !err_o);  // R7

   AST_NO_VALID_WITH_ERR: assert property (@(posedge clk_i) disable iff (rst_i)
      !(valid_o && err_o));  // R8

   AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !valid_o |-> $stable(word_o));  // R10
endmodule

bind ir_pulse_decoder ir_pulse_decoder_chk #(
   .CLK_PER_TICK(CLK_PER_TICK),
   .WORD_BITS   (WORD_BITS)
) u_chk (
   .clk_i  (clk_i),
   .rst_i  (rst_i),
   .tick   (tick),
   .word_o (word_o),
   .valid_o(valid_o),
   .err_o  (err_o)
);

// File: tb/test_ir_pulse_decoder.sv
module test_ir_pulse_decoder;
   localparam int CPT = 4;
   localparam int WB  = 12;
   localparam int GAP = 5;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          line = 1'b0;
   logic [WB-1:0] word;
   logic          valid, err;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   bit            exp_err[$];
   logic [WB-1:0] exp_word[$];
   string         exp_req[$];
   logic [WB-1:0] last_word = '0;

   always #5 clk = ~clk;

   ir_pulse_decoder #(.CLK_PER_TICK(CPT), .WORD_BITS(WB)) i_ir_pulse_decoder (
      .clk_i    (clk),
      .rst_i    (rst),
      .ir_line_i(line),
      .word_o   (word),
      .valid_o  (valid),
      .err_o    (err)
   );

   task automatic chk(input string req, input logic [WB-1:0] act, input logic [WB-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse(input int ticks);
      @(negedge clk) line = 1'b1;
      repeat (ticks * CPT) @(negedge clk);
      line = 1'b0;
      repeat (GAP * CPT) @(negedge clk);
   endtask

   task automatic expect_word(input logic [WB-1:0] w, input string req);
      exp_err.push_back(1'b0);
      exp_word.push_back(w);
      exp_req.push_back(req);
   endtask

   task automatic expect_err(input string req);
      exp_err.push_back(1'b1);
      exp_word.push_back('0);
      exp_req.push_back(req);
   endtask

   task automatic send_bits(input logic [WB-1:0] w, input int one_w, input int zero_w);
      for (int i = 0; i < WB; i++) pulse(w[i] ? one_w : zero_w);
   endtask

   // Monitor: pops the scoreboard whenever the design reports an event
   always @(negedge clk) begin
      if (!rst && (valid || err)) begin
         if (exp_err.size() == 0) begin
            checks++;
            fails++;
            $display("FAIL %s unexpected event actual valid=%0d err=%0d expected none",
                     valid ? "R4" : "R7", valid, err);
         end else begin
            automatic bit            e_err = exp_err.pop_front();
            automatic logic [WB-1:0] e_w   = exp_word.pop_front();
            automatic string         e_r   = exp_req.pop_front();
            chk({e_r, " kind"}, {11'd0, err}, {11'd0, e_err});
            if (!e_err) begin
               chk(e_r, word, e_w);
               last_word = e_w;
            end
         end
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R10 word", word, '0);
      chk("R10 valid", {11'd0, valid}, '0);
      chk("R10 err", {11'd0, err}, '0);

      // R6 R5: exact widths, LSB first
      expect_word(12'hA5C, "R5");
      pulse(25); send_bits(12'hA5C, 12, 6);

      // R4: data before start ignored; word held
      send_bits(12'h3C3, 12, 6);
      chk("R4 word held", word, last_word);
      expect_word(12'h001, "R6");
      pulse(25); send_bits(12'h001, 12, 6);

      // R3: window edges
      expect_word(12'hFFF, "R3 upper edges");
      pulse(27); send_bits(12'hFFF, 14, 8);
      expect_word(12'h6B2, "R3 lower edges");
      pulse(23); send_bits(12'h6B2, 10, 4);

      // R7: 9 ticks mid-frame, then 12 data pulses must be ignored
      expect_err("R7 mid-frame");
      pulse(25); pulse(12); pulse(6); pulse(9);
      send_bits(12'h5A5, 12, 6);
      chk("R7 word held", word, last_word);
      expect_err("R7 idle width 28");
      pulse(28);
      expect_word(12'h123, "R7 recovery");
      pulse(25); send_bits(12'h123, 12, 6);

      // R8: over-long pulses, one error each, fall not classified
      expect_err("R8 idle");
      pulse(45);
      expect_err("R8 mid-frame");
      pulse(25); pulse(12); pulse(12); pulse(50);
      send_bits(12'hF0F, 12, 6);
      expect_word(12'h800, "R8 recovery");
      pulse(25); send_bits(12'h800, 12, 6);

      // R9: start in mid-frame restarts collection
      expect_word(12'h9E1, "R9");
      pulse(25); pulse(12); pulse(12); pulse(6); pulse(12); pulse(12);
      pulse(25); send_bits(12'h9E1, 12, 6);

      // R2 R1: 40-tick pulse is measured (not long) and lies in no window
      expect_err("R2 width 40");
      pulse(40);

      repeat (50) @(negedge clk);
      chk("R6 queue drained", WB'(exp_err.size()), '0);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule